// File: doc/BRIEF.md
# Cache Miss Entry Controller

This block follows one outstanding cache-line miss from the cycle it is allocated to the cycle it frees itself. An allocation strobe supplies the request kind (load, store, atomic or prefetch), the block address, the virtual-address alias bits and a flag that marks a store covering the whole line. The entry then requests ownership from the next cache level on an acquire channel. It collects the grant beats into a line buffer and acknowledges the grant. It starts the refill in the cache pipeline early, as soon as the next level signals that the grant is about to arrive.

Control is a set of independent flags, not one encoded state. Each "send" flag records whether an outgoing request is still owed. Each "wait" flag records whether an expected response is still missing. All flags are true when the entry is idle, and allocation clears the ones the request needs. The entry is busy while any flag is still false. It releases itself when the pipeline reports that the refill, or the atomic operation, has finished.

Top module: `miss_entry`

## Requirements
- R1: After reset, busy, acqValid, ackValid, pipeReqValid and refillValid are all low.
- R2: An allocValid seen while the entry is idle makes busy high in the next cycle. From that cycle, entryBlockAddr, entryType and entryAlias show the captured request. entryPrefetch is high when the type is prefetch (type codes: load 0, store 1, atomic 2, prefetch 3). An allocValid seen while busy is ignored.
- R3: acqValid rises in the cycle after allocation and stays high until a cycle with acqReady high, then drops. acqAddr and acqAlias carry the captured block address and alias bits.
- R4: acqPerm is 1 (permission-only acquire) only for a store with allocFullOverwrite set. It is 0 (block acquire) for every other request, including a non-store with the flag set.
- R5: Grant beats presented before the acquire handshake are ignored: they cause no acknowledgment and are not stored.
- R6: ackValid is high for exactly one cycle, in the cycle after the first accepted grant beat, without waiting for the last beat.
- R7: pipeReqValid rises in the cycle after hintValid and stays high until pipeReqReady, then drops. It does not depend on grant data having arrived.
- R8: A data grant takes BEATS beats. Beat k lands in refillData bits [k*BEAT_W +: BEAT_W]. refillValid is a one-cycle pulse in the cycle after the last beat.
- R9: A grant with gntHasData low counts as the first and the last beat at once. The refilled line is then all zeros.
- R10: A pipeRespValid accepted after the last grant beat and after the pipeline request handshake clears busy in the next cycle. One arriving earlier is ignored. Atomic and non-atomic requests both release this way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Allocation strobe |
| allocType | input | 2 | Request kind: 0 load, 1 store, 2 atomic, 3 prefetch |
| allocBlockAddr | input | ADDR_W | Block address of the miss |
| allocFullOverwrite | input | 1 | Store overwrites the full line |
| allocAlias | input | ALIAS_W | Virtual-address alias bits |
| busy | output | 1 | Entry holds a miss |
| entryBlockAddr | output | ADDR_W | Captured block address, for merge checks |
| entryType | output | 2 | Captured request kind |
| entryAlias | output | ALIAS_W | Captured alias bits |
| entryPrefetch | output | 1 | Request came from a prefetcher |
| acqValid | output | 1 | Acquire request valid |
| acqReady | input | 1 | Acquire accepted |
| acqPerm | output | 1 | 1 = permission-only acquire, 0 = block acquire |
| acqAddr | output | ADDR_W | Acquire block address |
| acqAlias | output | ALIAS_W | Alias bits sent with the acquire |
| hintValid | input | 1 | Early notice that the grant follows |
| gntValid | input | 1 | Grant beat valid |
| gntHasData | input | 1 | Grant carries data |
| gntData | input | BEAT_W | Grant beat payload |
| ackValid | output | 1 | Grant acknowledgment |
| pipeReqValid | output | 1 | Early refill request to the pipeline |
| pipeReqReady | input | 1 | Pipeline accepted the refill request |
| pipeReqAddr | output | ADDR_W | Block address of the refill request |
| refillValid | output | 1 | Assembled line forwarded to pipeline stage 2 |
| refillData | output | BEATS*BEAT_W | Assembled line |
| pipeRespValid | input | 1 | Pipeline reports the refill or atomic done |

## Verification
A table of complete transactions covers each request kind. It pairs full-overwrite stores with a load that has the same flag set, which separates the two acquire flavours. It mixes two-beat data grants with a single dataless grant, which separates normal line assembly from the all-zero dataless case. Varying the delay before acqReady shows that the acquire is held, and the acknowledgment and refill pulses are timed against the exact beat that triggers them. Directed cases then present an allocation while busy, a grant beat before the acquire handshake, and a pipeline response before the refill. Each must leave the observed outputs untouched.

// File: rtl/miss_entry_pkg.sv
package miss_entry_pkg;
  typedef enum logic [1:0] {
    REQ_LOAD     = 2'd0,
    REQ_STORE    = 2'd1,
    REQ_ATOMIC   = 2'd2,
    REQ_PREFETCH = 2'd3
  } reqKind_e;

  // width of the beat index carried in the strobe struct (up to 16 beats)
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             alloc;
    logic             beatWr;
    logic [IDX_W-1:0] beatIdx;
    logic             lastBeat;
  } ctrlStb_t;
endpackage

// File: rtl/miss_entry_ctrl.sv
module miss_entry_ctrl
  import miss_entry_pkg::*;
#(
  parameter int BEATS = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     allocValid,
  input  logic     allocIsAtomic,
  input  logic     acqReady,
  input  logic     hintValid,
  input  logic     gntValid,
  input  logic     gntHasData,
  input  logic     pipeReqReady,
  input  logic     pipeRespValid,
  output logic     busy,
  output logic     acqValid,
  output logic     ackValid,
  output logic     pipeReqValid,
  output ctrlStb_t stb
);
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);

  // send flags: true = nothing owed; wait flags: true = nothing awaited
  logic sAcquire, sGrantAck, sPipeReq;
  logic wGrantFirst, wGrantLast, wL2Hint, wAtomicResp, wRefillDone;
  logic [CNT_W-1:0] beatCnt;

  logic allocFire, acqFire, gntFire, hintFire, pipeFire, respFire, isLast;

  assign busy         = !(sAcquire && sGrantAck && sPipeReq && wGrantFirst &&
                          wGrantLast && wL2Hint && wAtomicResp && wRefillDone);
  assign allocFire    = allocValid && !busy;
  assign acqValid     = !sAcquire;
  assign acqFire      = acqValid && acqReady;
  assign gntFire      = gntValid && sAcquire && !wGrantLast;
  assign isLast       = !gntHasData || (beatCnt == LAST_IDX);
  assign ackValid     = wGrantFirst && !sGrantAck;
  assign hintFire     = hintValid && !wL2Hint;
  assign pipeReqValid = wL2Hint && !sPipeReq;
  assign pipeFire     = pipeReqValid && pipeReqReady;
  assign respFire     = pipeRespValid && wGrantLast && sPipeReq &&
                        (!wAtomicResp || !wRefillDone);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sAcquire    <= 1'b1;
      sGrantAck   <= 1'b1;
      sPipeReq    <= 1'b1;
      wGrantFirst <= 1'b1;
      wGrantLast  <= 1'b1;
      wL2Hint     <= 1'b1;
      wAtomicResp <= 1'b1;
      wRefillDone <= 1'b1;
      beatCnt     <= '0;
    end else if (allocFire) begin
      sAcquire    <= 1'b0;
      sGrantAck   <= 1'b0;
      sPipeReq    <= 1'b0;
      wGrantFirst <= 1'b0;
      wGrantLast  <= 1'b0;
      wL2Hint     <= 1'b0;
      wAtomicResp <= !allocIsAtomic;
      wRefillDone <= allocIsAtomic;
      beatCnt     <= '0;
    end else begin
      if (acqFire) sAcquire <= 1'b1;
      if (gntFire) begin
        wGrantFirst <= 1'b1;
        if (isLast) wGrantLast <= 1'b1;
        else        beatCnt    <= beatCnt + 1'b1;
      end
      if (ackValid) sGrantAck <= 1'b1;
      if (hintFire) wL2Hint   <= 1'b1;
      if (pipeFire) sPipeReq  <= 1'b1;
      if (respFire) begin
        wAtomicResp <= 1'b1;
        wRefillDone <= 1'b1;
      end
    end
  end

  assign stb.alloc    = allocFire;
  assign stb.beatWr   = gntFire && gntHasData;
  assign stb.beatIdx  = IDX_W'(beatCnt);
  assign stb.lastBeat = gntFire && isLast;

  // R3
  acq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    acqValid && !acqReady |=> acqValid);
  // R6
  ack_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> !ackValid);
  // R7
  pipe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pipeReqValid && !pipeReqReady |=> pipeReqValid);
  // R2
  alloc_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(allocValid));
  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(pipeRespValid));
endmodule

// File: rtl/miss_entry_data.sv
module miss_entry_data
  import miss_entry_pkg::*;
#(
  parameter int ADDR_W  = 26,
  parameter int ALIAS_W = 2,
  parameter int BEAT_W  = 256,
  parameter int BEATS   = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStb_t                stb,
  input  logic [1:0]              allocType,
  input  logic [ADDR_W-1:0]       allocBlockAddr,
  input  logic                    allocFullOverwrite,
  input  logic [ALIAS_W-1:0]      allocAlias,
  input  logic [BEAT_W-1:0]       gntData,
  output logic [ADDR_W-1:0]       entryBlockAddr,
  output logic [1:0]              entryType,
  output logic [ALIAS_W-1:0]      entryAlias,
  output logic                    entryPrefetch,
  output logic                    acqPerm,
  output logic                    refillValid,
  output logic [BEATS*BEAT_W-1:0] refillData
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryBlockAddr <= '0;
      entryType      <= REQ_LOAD;
      entryAlias     <= '0;
      acqPerm        <= 1'b0;
      refillValid    <= 1'b0;
    end else begin
      if (stb.alloc) begin
        entryBlockAddr <= allocBlockAddr;
        entryType      <= allocType;
        entryAlias     <= allocAlias;
        acqPerm        <= allocFullOverwrite && (allocType == REQ_STORE);
      end
      refillValid <= stb.lastBeat;
    end
  end

  assign entryPrefetch = (entryType == REQ_PREFETCH);

  for (genvar g = 0; g < BEATS; g++) begin : gBeat
    logic [BEAT_W-1:0] slot;
    always_ff @(posedge clk) begin
      if (!rstN || stb.alloc)                             slot <= '0;
      else if (stb.beatWr && stb.beatIdx == IDX_W'(g))    slot <= gntData;
    end
    assign refillData[g*BEAT_W +: BEAT_W] = slot;
  end

  // R8
  refill_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    refillValid |=> !refillValid);
endmodule

// File: rtl/miss_entry.sv
module miss_entry
  import miss_entry_pkg::*;
#(
  parameter int ADDR_W  = 26,
  parameter int ALIAS_W = 2,
  parameter int BEAT_W  = 256,
  parameter int BEATS   = 2,
  localparam int LINE_W = BEATS * BEAT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               allocValid,
  input  logic [1:0]         allocType,
  input  logic [ADDR_W-1:0]  allocBlockAddr,
  input  logic               allocFullOverwrite,
  input  logic [ALIAS_W-1:0] allocAlias,
  output logic               busy,
  output logic [ADDR_W-1:0]  entryBlockAddr,
  output logic [1:0]         entryType,
  output logic [ALIAS_W-1:0] entryAlias,
  output logic               entryPrefetch,
  output logic               acqValid,
  input  logic               acqReady,
  output logic               acqPerm,
  output logic [ADDR_W-1:0]  acqAddr,
  output logic [ALIAS_W-1:0] acqAlias,
  input  logic               hintValid,
  input  logic               gntValid,
  input  logic               gntHasData,
  input  logic [BEAT_W-1:0]  gntData,
  output logic               ackValid,
  output logic               pipeReqValid,
  input  logic               pipeReqReady,
  output logic [ADDR_W-1:0]  pipeReqAddr,
  output logic               refillValid,
  output logic [LINE_W-1:0]  refillData,
  input  logic               pipeRespValid
);
  ctrlStb_t stb;

  miss_entry_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid),
    .allocIsAtomic(allocType == REQ_ATOMIC),
    .acqReady(acqReady), .hintValid(hintValid),
    .gntValid(gntValid), .gntHasData(gntHasData),
    .pipeReqReady(pipeReqReady), .pipeRespValid(pipeRespValid),
    .busy(busy), .acqValid(acqValid), .ackValid(ackValid),
    .pipeReqValid(pipeReqValid), .stb(stb)
  );

  miss_entry_data #(.ADDR_W(ADDR_W), .ALIAS_W(ALIAS_W), .BEAT_W(BEAT_W), .BEATS(BEATS)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .allocType(allocType), .allocBlockAddr(allocBlockAddr),
    .allocFullOverwrite(allocFullOverwrite), .allocAlias(allocAlias),
    .gntData(gntData),
    .entryBlockAddr(entryBlockAddr), .entryType(entryType),
    .entryAlias(entryAlias), .entryPrefetch(entryPrefetch),
    .acqPerm(acqPerm), .refillValid(refillValid), .refillData(refillData)
  );

  assign acqAddr     = entryBlockAddr;
  assign acqAlias    = entryAlias;
  assign pipeReqAddr = entryBlockAddr;
endmodule

// File: tb/miss_entry_tb.sv
module miss_entry_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 26, ALIAS_W = 2, BEAT_W = 256, BEATS = 2;
  localparam int LINE_W = BEATS * BEAT_W;
  localparam int N = 6;
  // vector columns: type, fullOverwrite, hasData, seed, alias, readyDelay, expected perm
  localparam int V_TYPE [N]  = '{0, 1, 1, 2, 3, 0};
  localparam int V_FO   [N]  = '{0, 1, 0, 0, 0, 1};
  localparam int V_DATA [N]  = '{1, 0, 1, 1, 1, 1};
  localparam int V_SEED [N]  = '{17, 34, 51, 68, 85, 102};
  localparam int V_ALIAS[N]  = '{1, 2, 3, 0, 1, 2};
  localparam int V_DLY  [N]  = '{0, 2, 1, 0, 3, 0};
  localparam int V_PERM [N]  = '{0, 1, 0, 0, 0, 0};

  logic clk = 0, rstN = 0;
  logic allocValid = 0, allocFullOverwrite = 0;
  logic [1:0] allocType = 0;
  logic [ADDR_W-1:0] allocBlockAddr = 0;
  logic [ALIAS_W-1:0] allocAlias = 0;
  logic acqReady = 0, hintValid = 0, gntValid = 0, gntHasData = 0;
  logic [BEAT_W-1:0] gntData = 0;
  logic pipeReqReady = 0, pipeRespValid = 0;
  logic busy, entryPrefetch, acqValid, acqPerm, ackValid, pipeReqValid, refillValid;
  logic [ADDR_W-1:0] entryBlockAddr, acqAddr, pipeReqAddr;
  logic [1:0] entryType;
  logic [ALIAS_W-1:0] entryAlias, acqAlias;
  logic [LINE_W-1:0] refillData;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  miss_entry u_dut (.*);

  task automatic check(string tag, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [BEAT_W-1:0] beatOf(int seed, int k);
    return {8{32'(seed * 16 + k)}};
  endfunction

  task automatic runTxn(int i);
    logic [ADDR_W-1:0] addr = ADDR_W'(32'h1000 + i * 7);
    logic [LINE_W-1:0] expLine = '0;
    if (V_DATA[i] != 0) expLine = {beatOf(V_SEED[i], 1), beatOf(V_SEED[i], 0)};
    allocValid = 1; allocType = 2'(V_TYPE[i]); allocBlockAddr = addr;
    allocFullOverwrite = V_FO[i][0]; allocAlias = ALIAS_W'(V_ALIAS[i]);
    @(negedge clk);
    allocValid = 0;
    check("R2 busy after alloc", LINE_W'(busy), 1);
    check("R2 entryBlockAddr", LINE_W'(entryBlockAddr), LINE_W'(addr));
    check("R2 entryType", LINE_W'(entryType), LINE_W'(V_TYPE[i]));
    check("R2 entryPrefetch", LINE_W'(entryPrefetch), LINE_W'(V_TYPE[i] == 3));
    check("R3 acqValid after alloc", LINE_W'(acqValid), 1);
    check("R3 acqAddr", LINE_W'(acqAddr), LINE_W'(addr));
    check("R3 acqAlias", LINE_W'(acqAlias), LINE_W'(V_ALIAS[i]));
    check("R4 acqPerm", LINE_W'(acqPerm), LINE_W'(V_PERM[i]));
    for (int d = 0; d < V_DLY[i]; d++) begin
      @(negedge clk);
      check("R3 acqValid held", LINE_W'(acqValid), 1);
    end
    acqReady = 1;
    @(negedge clk);
    acqReady = 0;
    check("R3 acqValid drops", LINE_W'(acqValid), 0);
    hintValid = 1;
    @(negedge clk);
    hintValid = 0;
    check("R7 pipeReqValid after hint", LINE_W'(pipeReqValid), 1);
    check("R7 pipeReqAddr", LINE_W'(pipeReqAddr), LINE_W'(addr));
    pipeReqReady = 1;
    gntValid = 1; gntHasData = V_DATA[i][0]; gntData = beatOf(V_SEED[i], 0);
    @(negedge clk);
    pipeReqReady = 0;
    check("R7 pipeReqValid drops", LINE_W'(pipeReqValid), 0);
    check("R6 ackValid after first beat", LINE_W'(ackValid), 1);
    if (V_DATA[i] != 0) begin
      check("R8 no refill before last beat", LINE_W'(refillValid), 0);
      gntData = beatOf(V_SEED[i], 1);
      @(negedge clk);
      check("R6 ackValid one cycle", LINE_W'(ackValid), 0);
      check("R8 refillValid after last beat", LINE_W'(refillValid), 1);
      check("R8 refillData", refillData, expLine);
    end else begin
      check("R9 dataless refillValid", LINE_W'(refillValid), 1);
      check("R9 dataless refillData", refillData, expLine);
    end
    gntValid = 0;
    @(negedge clk);
    check("R8 refillValid pulse", LINE_W'(refillValid), 0);
    check("R10 busy before resp", LINE_W'(busy), 1);
    pipeRespValid = 1;
    @(negedge clk);
    pipeRespValid = 0;
    check("R10 released", LINE_W'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", LINE_W'(busy), 0);
    check("R1 acqValid", LINE_W'(acqValid), 0);
    check("R1 ackValid", LINE_W'(ackValid), 0);
    check("R1 pipeReqValid", LINE_W'(pipeReqValid), 0);
    check("R1 refillValid", LINE_W'(refillValid), 0);
    rstN = 1;
    @(negedge clk);

    for (int i = 0; i < N; i++) runTxn(i);

    // directed: alloc while busy, early grant beat, early response
    allocValid = 1; allocType = 0; allocBlockAddr = 26'h0AAAA; allocAlias = 1;
    @(negedge clk);
    allocBlockAddr = 26'h05555; allocType = 1;
    @(negedge clk);
    allocValid = 0;
    check("R2 alloc while busy ignored addr", LINE_W'(entryBlockAddr), LINE_W'(26'h0AAAA));
    check("R2 alloc while busy ignored type", LINE_W'(entryType), 0);
    gntValid = 1; gntHasData = 1; gntData = beatOf(9, 9);
    pipeRespValid = 1;
    @(negedge clk);
    gntValid = 0; pipeRespValid = 0;
    check("R5 no ack before acquire", LINE_W'(ackValid), 0);
    check("R10 early resp ignored", LINE_W'(busy), 1);
    acqReady = 1;
    @(negedge clk);
    acqReady = 0; hintValid = 1;
    @(negedge clk);
    hintValid = 0; pipeReqReady = 1;
    gntValid = 1; gntData = beatOf(3, 0);
    @(negedge clk);
    pipeReqReady = 0; gntData = beatOf(3, 1);
    @(negedge clk);
    gntValid = 0;
    check("R5 early beat not stored", refillData, {beatOf(3, 1), beatOf(3, 0)});
    @(negedge clk);
    pipeRespValid = 1;
    @(negedge clk);
    pipeRespValid = 0;
    check("R10 release after refill", LINE_W'(busy), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule